// File: doc/BRIEF.md
# Gated Pulse-Count Frequency Digitizer

This block turns the pulse train of a voltage-to-frequency converter into a digital code. It counts the rising edges of that train inside a gate window. The gate is timed by dividing down the same master clock that drives the converter. Because of this, the code is a ratio of the two frequencies. Slow drift or jitter of the master clock therefore drops out of the result.

A conversion begins with a one-cycle start request while the block is idle. The gate length is taken from a length input, counted in master-clock periods. A length of zero selects a built-in default of 4096 periods. Long settings, such as a window spanning whole mains periods, are reached by widening the length parameter.

When the window closes, the count is latched onto the result port and a one-cycle done strobe is raised. A counter that fills up stops at all-ones and raises a sticky overflow flag. The pulse input is asynchronous, so a result may differ from the ideal count by one.

Top module: `pulse_count_digitizer`

## Requirements
- R1: While reset is asserted and right after it is released, `result_o`, `done_o`, `busy_o` and `ovf_o` are all 0.
- R2: A start request sampled high while `busy_o` is 0 raises `busy_o` on the next cycle. `done_o` is then high exactly N clock edges after the edge that accepted the start, where N is the effective gate length. In that same cycle `busy_o` is 0.
- R3: Only rising edges of `vfc_pulse_i` that are seen inside the gate window are counted. The latched result lies within one count of gate length divided by pulse period.
- R4: A `gate_len_i` value of 0 selects a gate length of DEF_GATE master-clock periods (default 4096). Any other value is used as given.
- R5: `done_o` is high for exactly one cycle per conversion and never without a start.
- R6: `result_o` changes only in a cycle where `done_o` is high. Between conversions it holds the last result.
- R7: A count that reaches all-ones stays there for the rest of the window and sets `ovf_o`. `ovf_o` stays high until the next accepted start clears it and the count.
- R8: A start request seen while `busy_o` is 1 has no effect. It neither restarts the window nor clears the count.
- R9: A pulse input held at a constant level for the whole window produces a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, the same clock that drives the converter |
| rst_n | input | 1 | Active-low asynchronous reset |
| vfc_pulse_i | input | 1 | Asynchronous pulse train from the converter |
| start_i | input | 1 | Conversion request, honoured only while idle |
| gate_len_i | input | GATE_W | Gate length in clock periods; 0 selects DEF_GATE |
| result_o | output | CNT_W | Latched count of the last conversion |
| done_o | output | 1 | One-cycle strobe when a new result is latched |
| busy_o | output | 1 | High while the gate window is open |
| ovf_o | output | 1 | Sticky flag: the count reached all-ones |

## Verification
The checker tests the following on every cycle:
- the count never moves while the gate is closed;
- done lasts one cycle and coincides with busy falling;
- the result register stays still outside done cycles;
- a saturated count and the overflow flag hold until an accepted start;
- a start request during busy does not clear a non-zero count.

Some behaviours can only be shown by the bench scenarios: the exact gate length counted from start to done, the default length selection, the ±1 accuracy of the count at several pulse rates, and the zero result for a steady input.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;

endpackage

// File: rtl/pcd_sync_edge.sv
module pcd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  // STAGES synchronising flops plus one history flop
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-1:0], async_i};
  end

  assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];

endmodule

// File: rtl/pcd_gate_gen.sv
module pcd_gate_gen
  import pcd_pkg::*;
#(
  parameter int GATE_W   = 24,
  parameter int DEF_GATE = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [GATE_W-1:0] gate_len_i,
  output logic              open_o,
  output logic              close_o,
  output logic              gate_o
);

  localparam logic [GATE_W-1:0] DEF_LEN = GATE_W'(DEF_GATE);

  gate_state_e       state_q;
  logic [GATE_W-1:0] remain_q;
  logic [GATE_W-1:0] len_eff;

  assign len_eff = (gate_len_i == '0) ? DEF_LEN : gate_len_i;
  assign open_o  = (state_q == GATE_IDLE) && start_i;
  assign close_o = (state_q == GATE_OPEN) && (remain_q == '0);
  assign gate_o  = (state_q == GATE_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= GATE_IDLE;
      remain_q <= '0;
    end else if (open_o) begin
      state_q  <= GATE_OPEN;
      remain_q <= len_eff - 1'b1;
    end else if (close_o) begin
      state_q  <= GATE_IDLE;
    end else if (state_q == GATE_OPEN) begin
      remain_q <= remain_q - 1'b1;
    end
  end

endmodule

// File: rtl/pcd_counter.sv
module pcd_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic             close_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] result_o,
  output logic             done_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, result_q;
  logic             ovf_q, ovf_nxt, done_q;

  always_comb begin
    if (clear_i)                        cnt_nxt = '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
    else                                cnt_nxt = cnt_q;
    ovf_nxt = clear_i ? 1'b0 : (ovf_q | (cnt_nxt == CNT_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      ovf_q  <= ovf_nxt;
      done_q <= close_i;
      if (close_i) result_q <= cnt_nxt;
    end
  end

  assign cnt_o    = cnt_q;
  assign result_o = result_q;
  assign done_o   = done_q;
  assign ovf_o    = ovf_q;

endmodule

// File: rtl/pulse_count_digitizer.sv
module pulse_count_digitizer #(
  parameter int CNT_W       = 24,
  parameter int GATE_W      = 24,
  parameter int DEF_GATE    = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vfc_pulse_i,
  input  logic              start_i,
  input  logic [GATE_W-1:0] gate_len_i,
  output logic [CNT_W-1:0]  result_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              ovf_o
);

  logic             pulse_rise;
  logic             gate_open, gate_close, gate;
  logic [CNT_W-1:0] cnt;

  pcd_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(vfc_pulse_i),
    .rise_o (pulse_rise)
  );

  pcd_gate_gen #(.GATE_W(GATE_W), .DEF_GATE(DEF_GATE)) i_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .gate_len_i(gate_len_i),
    .open_o    (gate_open),
    .close_o   (gate_close),
    .gate_o    (gate)
  );

  pcd_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (gate_open),
    .inc_i   (gate & pulse_rise),
    .close_i (gate_close),
    .cnt_o   (cnt),
    .result_o(result_o),
    .done_o  (done_o),
    .ovf_o   (ovf_o)
  );

  assign busy_o = gate;

endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovf_o,
  input logic [CNT_W-1:0] result_o,
  input logic             gate,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic accept;
  assign accept = start_i && !busy_o;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o && (cnt == '0)); // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o)); // R2

  AST_NO_CNT_OUTSIDE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !accept) |=> $stable(cnt)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R6

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !accept) |=> (cnt == CNT_MAX)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !accept) |=> ovf_o); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && cnt != '0) |=> (cnt != '0)); // R8

endmodule

bind pulse_count_digitizer pcd_checker #(.CNT_W(CNT_W)) i_pcd_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ovf_o   (ovf_o),
  .result_o(result_o),
  .gate    (gate),
  .cnt     (cnt)
);

// File: tb/test_pulse_count_digitizer.sv
module test_pulse_count_digitizer;

  localparam int CNT_W  = 12;
  localparam int GATE_W = 16;
  localparam int DEF_G  = 4096;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pin = 1'b0;
  logic              start = 1'b0;
  logic [GATE_W-1:0] glen = '0;
  logic [CNT_W-1:0]  result_o;
  logic              done_o, busy_o, ovf_o;

  pulse_count_digitizer #(.CNT_W(CNT_W), .GATE_W(GATE_W), .DEF_GATE(DEF_G)) i_pulse_count_digitizer (
    .clk        (clk),
    .rst_n      (rst_n),
    .vfc_pulse_i(pin),
    .start_i    (start),
    .gate_len_i (glen),
    .result_o   (result_o),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .ovf_o      (ovf_o)
  );

  always #10 clk = ~clk; // 50 MHz

  typedef struct {
    int    exp;
    bit    ovf;
    bit    exact;
    string req;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_e;
  int   n_tests = 0;
  int   n_fail  = 0;
  int   period  = 0;
  int   ph      = 0;
  int   last_result = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // pulse source: 0 = held low, 1 = held high, else square wave of that period
  always @(negedge clk) begin
    if (period == 0)      pin <= 1'b0;
    else if (period == 1) pin <= 1'b1;
    else begin
      pin <= (ph < period / 2);
      ph  <= (ph + 1 >= period) ? 0 : ph + 1;
    end
  end

  // monitor: pops the scoreboard on each done strobe
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R5", "done without start", 1, 0);
      end else begin
        int d;
        mon_e = sb_q.pop_front();
        d = int'(result_o) - mon_e.exp;
        if (mon_e.exact) check(d == 0, mon_e.req, "result", int'(result_o), mon_e.exp);
        else             check(d >= -1 && d <= 1, mon_e.req, "result +-1", int'(result_o), mon_e.exp);
        check(ovf_o == mon_e.ovf, "R7", "ovf at done", int'(ovf_o), int'(mon_e.ovf));
      end
    end
  end

  task automatic run(input int n, input int per, input int expv, input bit eovf,
                     input bit exact, input int late_start, input string req);
    int eff;
    int lat;
    eff = (n == 0) ? DEF_G : n;
    period = per;
    glen = GATE_W'(n);
    repeat (8) @(negedge clk);
    sb_q.push_back('{expv, eovf, exact, req});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
    check(int'(result_o) == last_result, "R6", "result held", int'(result_o), last_result);
    check(ovf_o == 1'b0, "R7", "ovf cleared by start", int'(ovf_o), 0);
    lat = 0;
    while (!done_o && lat < eff + 10) begin
      @(negedge clk);
      lat++;
      start = (late_start != 0 && lat == late_start);
    end
    start = 1'b0;
    check(lat == eff, (late_start != 0) ? "R8" : ((n == 0) ? "R4" : "R2"),
          "start-to-done latency", lat, eff);
    check(busy_o == 1'b0, "R2", "busy low with done", int'(busy_o), 0);
    @(negedge clk);
    check(done_o == 1'b0, "R5", "done one cycle", int'(done_o), 0);
    last_result = int'(result_o);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(result_o == '0, "R1", "result in reset", int'(result_o), 0);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    check(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    check(ovf_o == 1'b0, "R1", "ovf in reset", int'(ovf_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset", int'(busy_o), 0);

    run(0,     10, 409,  1'b0, 1'b0, 0,   "R4");  // default gate length
    run(1000,  3,  333,  1'b0, 1'b0, 0,   "R3");
    run(500,   1,  0,    1'b0, 1'b1, 0,   "R9");  // steady high input
    run(12000, 2,  4095, 1'b1, 1'b1, 0,   "R7");  // saturation
    repeat (5) @(negedge clk);
    check(ovf_o == 1'b1, "R7", "ovf sticky after done", int'(ovf_o), 1);
    check(result_o == 12'hFFF, "R6", "result held after done", int'(result_o), 4095);
    run(200,   4,  50,   1'b0, 1'b0, 0,   "R3");
    run(300,   5,  60,   1'b0, 1'b0, 100, "R8");  // start while busy
    run(1,     0,  0,    1'b0, 1'b1, 0,   "R2");  // shortest gate
    run(64,    0,  0,    1'b0, 1'b1, 0,   "R9");  // steady low input

    repeat (10) @(negedge clk);
    check(sb_q.size() == 0, "R5", "all results seen", sb_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule